// File: doc/BRIEF.md
# Pixel Word Unpacker and Panel Bus Mapper

This block sits between a pixel FIFO that delivers 32-bit memory words and a parallel RGB panel bus. It takes one word at a time through a valid/ready handshake. It splits the word into pixels and sends them out one per accepted output beat, again through a valid/ready handshake. The output is a 24-bit pixel bus. Only the low 16, 18 or all 24 lines carry colour, depending on the panel width selected.

Two word layouts are understood. The first is a pair of 16-bit RGB565 pixels, with all four bytes valid. The second is a single 24-bit RGB888 pixel in the low three bytes, with the top byte discarded. The word-length code and the byte-valid mask together select the layout. A word in any other layout is consumed and produces no pixel. For 24-bit pixels on narrower panels, each colour component is cut down to its most significant bits. An optional reduction flag forces the 18-bit form even on a 24-line panel. A flush input empties the holding stage at once, so that a stale half-used word can never shift the picture.

Top module: `pxu_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With word-length code 0 and byte mask 0xF, a word yields two RGB565 pixels: bits 15:0 first, then bits 31:16.
- R3: While a word is held, `in_ready` stays 0. It returns to 1 only in the cycle after the last pixel of that word has been accepted. In pair mode, `out_valid` stays 1 between the first and the second pixel without any new input.
- R4: With word-length code 3 and byte mask 0x7, a word yields exactly one pixel taken from bits 23:0 (red 23:16, green 15:8, blue 7:0). Bits 31:24 have no effect on the output.
- R5: A 24-bit pixel on bus code 3 (24 lines) with the reduction flag clear appears unchanged on `out_pixel[23:0]`.
- R6: A 24-bit pixel on bus code 2 (18 lines), or on bus code 3 with `reduce18` set, appears as {R[7:2],G[7:2],B[7:2]} on bits 17:0, with bits 23:18 at 0.
- R7: A 24-bit pixel on bus code 0 (16 lines) appears as {R[7:3],G[7:2],B[7:3]} on bits 15:0, with bits 23:16 at 0.
- R8: A 16-bit pixel on bus code 0, 2 or 3 appears unchanged on bits 15:0, with bits 23:16 at 0, whatever the value of `reduce18`.
- R9: A word with any other pairing of word-length code and mask is accepted, and no pixel is emitted for it. This covers word-length code 1 (8 bpp), code 2, code 0 with mask other than 0xF, and code 3 with mask other than 0x7.
- R10: On bus code 1 (8 lines), pixels are still handed out one per beat, but `out_pixel` is all zero.
- R11: A cycle with `flush` high discards the held word and any remaining pixel. During that cycle `in_ready` and `out_valid` are 0. The next pixel out comes from the next word accepted.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_pixel` holds its value, provided the configuration inputs are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held word and pending pixels |
| wlen_code | input | 2 | Word length: 0 = 16 bpp, 1 = 8 bpp, 3 = 24 bpp |
| byte_mask | input | 4 | Valid bytes of each word (0xF or 0x7 used) |
| reduce18 | input | 1 | Force 18-bit reduction of 24-bit pixels |
| bus_code | input | 2 | Panel width: 0 = 16, 1 = 8, 2 = 18, 3 = 24 lines |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Pixel on `out_pixel` is valid |
| out_pixel | output | 24 | Panel bus data, unused lines zero |
| out_ready | input | 1 | Panel side takes the pixel |

## Verification
The bench goes after the order of the two halves of a packed word. A design that swapped them would draw every pair of pixels mirrored. It also covers the gap between the two halves: a design that raised `in_ready` early would overwrite the upper pixel. Top-byte garbage in 24-bit words is used to catch a design that leaks bits 31:24 onto the bus. Unsupported layouts are sent to catch one that emits a phantom pixel and so shifts the whole line. A flush in the middle of a packed word checks that the next picture starts on a fresh word rather than on the stale upper half. The reduction cases use component values whose low bits differ from their high bits, so that a truncation taken from the wrong end is seen.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
   // word-length codes
   localparam logic [1:0] WLEN_16 = 2'd0;
   localparam logic [1:0] WLEN_8  = 2'd1;
   localparam logic [1:0] WLEN_24 = 2'd3;
   // byte-valid masks
   localparam logic [3:0] MASK_PAIR   = 4'hF;
   localparam logic [3:0] MASK_SINGLE = 4'h7;
   // panel bus width codes
   localparam logic [1:0] BUS_16 = 2'd0;
   localparam logic [1:0] BUS_8  = 2'd1;
   localparam logic [1:0] BUS_18 = 2'd2;
   localparam logic [1:0] BUS_24 = 2'd3;

   typedef enum logic [1:0] {
      SLOT_DROP   = 2'd0,
      SLOT_PAIR   = 2'd1,
      SLOT_SINGLE = 2'd2
   } slot_kind_e;
endpackage

// File: rtl/pxu_word_slot.sv
module pxu_word_slot
   import pxu_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        wlen_code,
   input  logic [3:0]        byte_mask,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   output logic              full,
   output logic              phase,
   output slot_kind_e        kind,
   output logic [WORD_W-1:0] word
);
   slot_kind_e kind_now;
   logic       load;

   always_comb begin
      if (wlen_code == WLEN_16 && byte_mask == MASK_PAIR)
         kind_now = SLOT_PAIR;
      else if (wlen_code == WLEN_24 && byte_mask == MASK_SINGLE)
         kind_now = SLOT_SINGLE;
      else
         kind_now = SLOT_DROP;
   end

   assign in_ready = ~full & ~flush;
   assign load     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full  <= 1'b0;
         phase <= 1'b0;
         kind  <= SLOT_DROP;
         word  <= '0;
      end else if (flush) begin
         full  <= 1'b0;
         phase <= 1'b0;
      end else if (load) begin
         word  <= in_data;
         kind  <= kind_now;
         full  <= (kind_now != SLOT_DROP);
         phase <= 1'b0;
      end else if (take) begin
         if (kind == SLOT_PAIR && !phase) begin
            phase <= 1'b1;
         end else begin
            full  <= 1'b0;
            phase <= 1'b0;
         end
      end
   end

   // R3: after the lower half leaves, the word stays held for the upper half
   assert_pair_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !flush && kind == SLOT_PAIR && !phase) |=> (full && phase && !in_ready));

   // R9: an unsupported layout never becomes a pending pixel
   assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && kind_now == SLOT_DROP) |=> !full);
endmodule

// File: rtl/pxu_pixel_pick.sv
module pxu_pixel_pick
   import pxu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 24
) (
   input  logic [WORD_W-1:0] word,
   input  slot_kind_e        kind,
   input  logic              phase,
   output logic [PIX_W-1:0]  raw_pix,
   output logic              is16
);
   localparam int HALF_W = WORD_W / 2;

   logic [HALF_W-1:0] half;

   assign half = phase ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
   assign is16 = (kind == SLOT_PAIR);

   always_comb begin
      if (is16)
         raw_pix = {{(PIX_W-HALF_W){1'b0}}, half};
      else
         raw_pix = word[PIX_W-1:0];
   end
endmodule

// File: rtl/pxu_bus_map.sv
module pxu_bus_map
   import pxu_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int RED_W  = 6,
   parameter int NARROW_W = 5
) (
   input  logic [3*COMP_W-1:0] raw_pix,
   input  logic                is16,
   input  logic [1:0]          bus_code,
   input  logic                reduce18,
   output logic [3*COMP_W-1:0] bus_pix
);
   localparam int PIX_W = 3 * COMP_W;
   localparam int R18_W = 3 * RED_W;
   localparam int R16_W = 2 * NARROW_W + RED_W;
   localparam int H16_W = 16;

   logic [RED_W-1:0]    top6 [3];
   logic [NARROW_W-1:0] top5 [3];

   // channel 0 = blue, 1 = green, 2 = red
   for (genvar c = 0; c < 3; c++) begin : g_chan
      assign top6[c] = raw_pix[c*COMP_W + COMP_W - 1 -: RED_W];
      assign top5[c] = raw_pix[c*COMP_W + COMP_W - 1 -: NARROW_W];
   end

   logic [R18_W-1:0] pix18;
   logic [R16_W-1:0] pix16;
   assign pix18 = {top6[2], top6[1], top6[0]};
   assign pix16 = {top5[2], top6[1], top5[0]};

   always_comb begin
      if (bus_code == BUS_8)
         bus_pix = '0;
      else if (is16)
         bus_pix = {{(PIX_W-H16_W){1'b0}}, raw_pix[H16_W-1:0]};
      else if (bus_code == BUS_16)
         bus_pix = {{(PIX_W-R16_W){1'b0}}, pix16};
      else if (bus_code == BUS_18 || reduce18)
         bus_pix = {{(PIX_W-R18_W){1'b0}}, pix18};
      else
         bus_pix = raw_pix;
   end
endmodule

// File: rtl/pxu_top.sv
module pxu_top
   import pxu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int COMP_W = 8,
   parameter int RED_W  = 6,
   parameter int NARROW_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic [1:0]          wlen_code,
   input  logic [3:0]          byte_mask,
   input  logic                reduce18,
   input  logic [1:0]          bus_code,
   input  logic                in_valid,
   input  logic [WORD_W-1:0]   in_data,
   output logic                in_ready,
   output logic                out_valid,
   output logic [3*COMP_W-1:0] out_pixel,
   input  logic                out_ready
);
   localparam int PIX_W = 3 * COMP_W;

   if (WORD_W != 32) begin : g_bad_word
      $error("pxu_top: WORD_W must be 32");
   end
   if (PIX_W != 24 || RED_W >= COMP_W || NARROW_W >= RED_W) begin : g_bad_comp
      $error("pxu_top: component widths inconsistent");
   end

   logic              full, phase, take, is16;
   slot_kind_e        kind;
   logic [WORD_W-1:0] word;
   logic [PIX_W-1:0]  raw_pix;

   assign out_valid = full & ~flush;
   assign take      = out_valid & out_ready;

   pxu_word_slot #(.WORD_W(WORD_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wlen_code(wlen_code), .byte_mask(byte_mask),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .take(take), .full(full), .phase(phase), .kind(kind), .word(word)
   );

   pxu_pixel_pick #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_pick (
      .word(word), .kind(kind), .phase(phase),
      .raw_pix(raw_pix), .is16(is16)
   );

   pxu_bus_map #(.COMP_W(COMP_W), .RED_W(RED_W), .NARROW_W(NARROW_W)) u_map (
      .raw_pix(raw_pix), .is16(is16), .bus_code(bus_code),
      .reduce18(reduce18), .bus_pix(out_pixel)
   );

   // R11: a flush leaves nothing pending
   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

   // R12: an unaccepted pixel stays offered
   assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> out_valid);

   // R8: packed pixels never drive the upper lines
   assert_pair_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && kind == SLOT_PAIR) |-> (out_pixel[PIX_W-1:16] == '0));

   // R10: the 8-line bus carries no colour
   assert_bus8_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && bus_code == BUS_8) |-> (out_pixel == '0));
endmodule

// File: tb/pxu_top_tb.sv
`timescale 1ns/1ps
module pxu_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  wlen_code = 2'd0;
   logic [3:0]  byte_mask = 4'hF;
   logic        reduce18 = 1'b0;
   logic [1:0]  bus_code = 2'd0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [23:0] out_pixel;
   logic        out_ready = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   pxu_top u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wlen_code(wlen_code),
      .byte_mask(byte_mask), .reduce18(reduce18), .bus_code(bus_code),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_pixel(out_pixel), .out_ready(out_ready)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected panel value from the requirements
   function automatic logic [23:0] model_pix(input logic pair, input logic hi,
                                              input logic [1:0] bus, input logic red,
                                              input logic [31:0] w);
      logic [7:0] r, g, b;
      r = w[23:16]; g = w[15:8]; b = w[7:0];
      if (bus == 2'd1) return 24'h0;                           // R10
      if (pair) return {8'h0, hi ? w[31:16] : w[15:0]};         // R2, R8
      if (bus == 2'd0) return {8'h0, r[7:3], g[7:2], b[7:3]};   // R7
      if (bus == 2'd2 || red) return {6'h0, r[7:2], g[7:2], b[7:2]}; // R6
      return w[23:0];                                           // R5
   endfunction

   task automatic send_word(input logic [31:0] w);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;
   endtask

   task automatic take_pixel(input string req, input logic [23:0] exp, input int stalls);
      for (int k = 0; k < stalls; k++) begin
         out_ready = 1'b0;
         chk("R12 valid held", {31'b0, out_valid}, 32'd1);
         chk("R12 pixel held", {8'h0, out_pixel}, {8'h0, exp});
         @(negedge clk);
      end
      chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
      chk({req, " pixel"}, {8'h0, out_pixel}, {8'h0, exp});
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] wl, input logic [3:0] m,
                          input logic [1:0] bus, input logic red);
      wlen_code = wl; byte_mask = m; bus_code = bus; reduce18 = red;
   endtask

   task automatic run_pair(input logic [31:0] w, input int st);
      send_word(w);
      take_pixel("R2 low half", model_pix(1'b1, 1'b0, bus_code, reduce18, w), st);
      chk("R3 ready low between halves", {31'b0, in_ready}, 32'd0);
      chk("R3 valid kept between halves", {31'b0, out_valid}, 32'd1);
      take_pixel("R2 high half", model_pix(1'b1, 1'b1, bus_code, reduce18, w), st);
      chk("R3 ready after last pixel", {31'b0, in_ready}, 32'd1);
      chk("R3 empty after last pixel", {31'b0, out_valid}, 32'd0);
   endtask

   task automatic run_single(input string req, input logic [31:0] w, input int st);
      send_word(w);
      take_pixel(req, model_pix(1'b0, 1'b0, bus_code, reduce18, w), st);
      chk("R4 one pixel per word", {31'b0, out_valid}, 32'd0);
      chk("R4 ready after pixel", {31'b0, in_ready}, 32'd1);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
      chk("R1 reset in_ready", {31'b0, in_ready}, 32'd1);

      // R2 / R8 directed, several buses
      set_cfg(2'd0, 4'hF, 2'd0, 1'b0);
      run_pair(32'hABCD_1234, 0);
      set_cfg(2'd0, 4'hF, 2'd3, 1'b1);
      run_pair(32'hF00F_8001, 1);
      set_cfg(2'd0, 4'hF, 2'd2, 1'b0);
      run_pair(32'h5555_AAAA, 2);

      // R4 / R5: top byte garbage ignored
      set_cfg(2'd3, 4'h7, 2'd3, 1'b0);
      run_single("R5 full 24", 32'hFF12_3456, 0);
      run_single("R4 top byte ignored", 32'h0012_3456, 0);
      // R6 both routes
      set_cfg(2'd3, 4'h7, 2'd2, 1'b0);
      run_single("R6 bus18", 32'hA5C3_7E81, 1);
      set_cfg(2'd3, 4'h7, 2'd3, 1'b1);
      run_single("R6 reduce flag", 32'h00C3_7E81, 0);
      // R7
      set_cfg(2'd3, 4'h7, 2'd0, 1'b0);
      run_single("R7 bus16", 32'h77FF_0FF0, 0);
      // R10
      set_cfg(2'd3, 4'h7, 2'd1, 1'b0);
      run_single("R10 bus8", 32'h00FF_FFFF, 0);

      // R9 unsupported layouts: consumed, nothing out
      begin
         logic [1:0] wls [4] = '{2'd1, 2'd2, 2'd0, 2'd3};
         logic [3:0] ms  [4] = '{4'hF, 4'hF, 4'h7, 4'hF};
         for (int i = 0; i < 4; i++) begin
            set_cfg(wls[i], ms[i], 2'd3, 1'b0);
            send_word(32'hDEAD_BEEF);
            chk("R9 no pixel", {31'b0, out_valid}, 32'd0);
            chk("R9 word consumed", {31'b0, in_ready}, 32'd1);
         end
      end

      // R11: flush mid word
      set_cfg(2'd0, 4'hF, 2'd0, 1'b0);
      send_word(32'h1111_2222);
      take_pixel("R11 before flush", 24'h002222, 0);
      flush = 1'b1;
      #0.1;
      chk("R11 valid low during flush", {31'b0, out_valid}, 32'd0);
      chk("R11 ready low during flush", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      chk("R11 empty after flush", {31'b0, out_valid}, 32'd0);
      run_pair(32'h3333_4444, 0);

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [31:0] w;
         int st;
         w  = $urandom;
         st = $urandom_range(0, 2);
         bus_code = 2'($urandom_range(0, 3));
         reduce18 = 1'($urandom);
         if ($urandom_range(0, 1) == 0) begin
            wlen_code = 2'd0; byte_mask = 4'hF;
            run_pair(w, st);
         end else begin
            wlen_code = 2'd3; byte_mask = 4'h7;
            run_single("R4 random single", w, st);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule